// File: doc/BRIEF.md
# User-Mode CSR and Trap Unit

This block is the control-and-status register unit of a small 32-bit core that runs only at the user privilege level. Each cycle it can perform one register access: it returns the old value of the addressed register and, depending on the operation, writes the operand into it, ORs the operand in, or clears the bits the operand marks. The core decodes the instruction before it reaches this block. For the immediate forms, the core zero-extends the 5-bit constant onto the operand bus. The core also raises the source-is-zero flag when the source register is x0, or when the immediate is zero.

The unit holds the trap registers: status, interrupt enable, handler base, scratch, saved PC, cause and bad value. It also has a read-only view of interrupt pending and three 64-bit counters: cycles, time ticks and retired instructions. The trap decision is made in one cycle and comes from three sources: a synchronous exception reported by the core, an illegal register access detected here, and an enabled timer interrupt. The unit records the PC and cause and, in the following cycle, asks the core to redirect fetch to the handler base. A return-from-trap request redirects fetch, in the following cycle, to the saved PC.

A sequencer with three states drives this. RUN accepts requests. RUN goes to TRAP_JUMP when a trap is taken and to RET_JUMP when a return is accepted. TRAP_JUMP and RET_JUMP each last one cycle: they present the redirect and then go back to RUN.

Top module: `utrap_csr_unit`

## Requirements
- R1: After reset, every trap register reads 0 and no redirect is presented. The sequencer is in RUN and the counters are 0.
- R2: The register addresses are: status 0x000, interrupt enable 0x004, handler base 0x005, scratch 0x040, saved PC 0x041, cause 0x042, bad value 0x043, pending 0x044. The counter low halves are at 0xC00 (cycles), 0xC01 (time) and 0xC02 (retired); their high halves are at 0xC80, 0xC81 and 0xC82. Pending bit 4 shows the live timer request; all other pending bits read 0. Any other address reads 0. The read data is combinational from the address.
- R3: The operation codes are 01 write, 10 set and 11 clear. Each returns the old value. Write replaces the register, set ORs the operand in, and clear removes the operand's 1 bits. Only status bits 0 and 4 and enable bits 0, 4 and 8 are stored. The handler base and saved PC force bits 1:0 to 0. Writes to pending have no effect.
- R4: Operation code 00 never writes. Set and clear do not write when the source-is-zero flag is high.
- R5: The cycle counter rises by one every clock, time by one on each tick, and retired by one on each retire pulse. Each counter is 64 bits, with a carry from the low half into the high half.
- R6: Certain accesses are illegal: any access to an unlisted address, and any writing access (write, or set or clear without the source-is-zero flag) to a counter address. An illegal access writes nothing. It takes a trap with cause 2, saved PC = current PC with bits 1:0 cleared, and bad value 0.
- R7: A synchronous exception stores the PC (bits 1:0 cleared), the cause with bit 31 clear and the 31-bit code below it, and the given bad value. In the next cycle the redirect shows the handler base.
- R8: Taking any trap copies status bit 0 into status bit 4 and clears status bit 0.
- R9: A timer interrupt is taken in RUN when status bit 0, enable bit 4 and the request are all 1. Its cause is 0x80000004 and it saves the current PC. In that cycle it overrides a register access or a return, which has no effect.
- R10: An accepted return redirects, in the next cycle, to the saved PC. It also sets status bit 0 from bit 4 and sets bit 4 to 1.
- R11: Within one RUN cycle, the priority order is: exception, then illegal access, then interrupt, then register access, then return. A return is not accepted while an access is valid.
- R12: The redirect lasts exactly one cycle. Every request and interrupt during that cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| csr_valid_i | input | 1 | Register access request |
| csr_op_i | input | 2 | Operation code (R3, R4) |
| csr_addr_i | input | 12 | Register address |
| csr_operand_i | input | 32 | Source value or zero-extended constant |
| csr_src_zero_i | input | 1 | Source is x0 or constant is zero |
| csr_rdata_o | output | 32 | Old value of the addressed register |
| pc_i | input | 32 | PC of the current instruction |
| exc_valid_i | input | 1 | Synchronous exception request |
| exc_code_i | input | 31 | Exception code |
| exc_tval_i | input | 32 | Exception bad value |
| ret_valid_i | input | 1 | Return-from-trap request |
| retire_i | input | 1 | Instruction retired pulse |
| time_tick_i | input | 1 | Time base tick |
| irq_timer_i | input | 1 | Timer interrupt request |
| redirect_valid_o | output | 1 | Fetch redirect strobe |
| redirect_pc_o | output | 32 | Fetch redirect target |

## Verification
The conditions that are hardest to reach are collisions in the same cycle. One is a timer interrupt arriving together with a legal write. Another is an exception arriving together with an illegal access. A third is a request arriving during the one-cycle redirect window. Reaching any of them takes setup first: the handler base, the global enable and the timer enable are each programmed through earlier accesses. Then the colliding inputs are driven in a single cycle. A behavioural model in the bench predicts the winner, the stored cause and the target. Follow-up reads then show that the losing request left the scratch, cause and status registers untouched.

// File: rtl/utrap_pkg.sv
package utrap_pkg;
    localparam int XLEN    = 32;
    localparam int CNT_W   = 64;
    localparam int NUM_CNT = 3;

    typedef enum logic [1:0] {
        OP_READ  = 2'b00,
        OP_WRITE = 2'b01,
        OP_SET   = 2'b10,
        OP_CLEAR = 2'b11
    } csr_op_e;

    typedef enum logic [1:0] {
        ST_RUN       = 2'd0,
        ST_TRAP_JUMP = 2'd1,
        ST_RET_JUMP  = 2'd2
    } seq_state_e;

    localparam logic [11:0] A_STATUS  = 12'h000;
    localparam logic [11:0] A_IE      = 12'h004;
    localparam logic [11:0] A_TVEC    = 12'h005;
    localparam logic [11:0] A_SCRATCH = 12'h040;
    localparam logic [11:0] A_EPC     = 12'h041;
    localparam logic [11:0] A_CAUSE   = 12'h042;
    localparam logic [11:0] A_TVAL    = 12'h043;
    localparam logic [11:0] A_IP      = 12'h044;
    localparam logic [11:0] A_CNT     = 12'hC00;
    localparam logic [11:0] CNT_AMASK = 12'hF7C;

    localparam int GIE_BIT   = 0;
    localparam int PGIE_BIT  = 4;
    localparam int TIMER_BIT = 4;

    localparam logic [XLEN-1:0] STATUS_WMASK    = 32'h0000_0011;
    localparam logic [XLEN-1:0] IE_WMASK        = 32'h0000_0111;
    localparam logic [XLEN-1:0] ALIGN_MASK      = 32'hFFFF_FFFC;
    localparam logic [XLEN-1:0] CAUSE_ILLEGAL   = 32'd2;
    localparam logic [XLEN-1:0] CAUSE_TIMER_IRQ = 32'h8000_0004;
endpackage

// File: rtl/utrap_counters.sv
module utrap_counters
    import utrap_pkg::*;
#(
    parameter int W = CNT_W,
    parameter int N = NUM_CNT
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [N-1:0]        inc_i,
    output logic [N-1:0][W-1:0] cnt_o
);
    localparam int HALF = W / 2;

    for (genvar g = 0; g < N; g++) begin : g_cnt
        logic [HALF-1:0] lo_q;
        logic [HALF-1:0] hi_q;

        // low half counts, high half takes the carry
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                lo_q <= '0;
                hi_q <= '0;
            end else if (inc_i[g]) begin
                lo_q <= lo_q + 1'b1;
                if (&lo_q) begin
                    hi_q <= hi_q + 1'b1;
                end
            end
        end

        assign cnt_o[g] = {hi_q, lo_q};
    end
endmodule

// File: rtl/utrap_regs.sv
module utrap_regs
    import utrap_pkg::*;
#(
    parameter int W = CNT_W,
    parameter int N = NUM_CNT
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [11:0]         addr_i,
    input  csr_op_e             op_i,
    input  logic [XLEN-1:0]     operand_i,
    input  logic                src_zero_i,
    input  logic                csr_we_i,
    input  logic                trap_en_i,
    input  logic [XLEN-1:0]     trap_cause_i,
    input  logic [XLEN-1:0]     trap_tval_i,
    input  logic [XLEN-1:0]     pc_i,
    input  logic                ret_en_i,
    input  logic                irq_timer_i,
    input  logic [N-1:0][W-1:0] cnt_i,
    output logic [XLEN-1:0]     rdata_o,
    output logic                illegal_o,
    output logic                write_req_o,
    output logic                irq_hit_o,
    output logic                status_ie_o,
    output logic                status_pie_o,
    output logic [XLEN-1:0]     tvec_o,
    output logic [XLEN-1:0]     epc_o
);
    localparam int HALF = W / 2;

    logic [XLEN-1:0] status_q, ie_q, tvec_q, scratch_q, epc_q, cause_q, tval_q;
    logic [XLEN-1:0] new_val;
    logic [W-1:0]    cnt_pick;
    logic [XLEN-1:0] cnt_word;
    logic            cnt_hit;
    logic            addr_ok;

    always_comb begin
        cnt_pick = '0;
        for (int k = 0; k < N; k++) begin
            if (addr_i[1:0] == k[1:0]) begin
                cnt_pick = cnt_i[k];
            end
        end
    end

    assign cnt_hit  = ((addr_i & CNT_AMASK) == A_CNT) && (int'(addr_i[1:0]) < N);
    assign cnt_word = addr_i[7] ? cnt_pick[W-1:HALF] : cnt_pick[HALF-1:0];

    always_comb begin
        rdata_o = '0;
        addr_ok = 1'b1;
        case (addr_i)
            A_STATUS:  rdata_o = status_q;
            A_IE:      rdata_o = ie_q;
            A_TVEC:    rdata_o = tvec_q;
            A_SCRATCH: rdata_o = scratch_q;
            A_EPC:     rdata_o = epc_q;
            A_CAUSE:   rdata_o = cause_q;
            A_TVAL:    rdata_o = tval_q;
            A_IP:      rdata_o = XLEN'(irq_timer_i) << TIMER_BIT;
            default: begin
                if (cnt_hit) begin
                    rdata_o = cnt_word;
                end else begin
                    addr_ok = 1'b0;
                end
            end
        endcase
    end

    always_comb begin
        unique case (op_i)
            OP_WRITE: new_val = operand_i;
            OP_SET:   new_val = rdata_o | operand_i;
            OP_CLEAR: new_val = rdata_o & ~operand_i;
            OP_READ:  new_val = rdata_o;
        endcase
    end

    assign write_req_o = (op_i == OP_WRITE) ||
                         (((op_i == OP_SET) || (op_i == OP_CLEAR)) && !src_zero_i);
    assign illegal_o   = !addr_ok || (cnt_hit && write_req_o);
    assign irq_hit_o   = status_q[GIE_BIT] && ie_q[TIMER_BIT] && irq_timer_i;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            status_q  <= '0;
            ie_q      <= '0;
            tvec_q    <= '0;
            scratch_q <= '0;
            epc_q     <= '0;
            cause_q   <= '0;
            tval_q    <= '0;
        end else if (trap_en_i) begin
            epc_q              <= pc_i & ALIGN_MASK;
            cause_q            <= trap_cause_i;
            tval_q             <= trap_tval_i;
            status_q[PGIE_BIT] <= status_q[GIE_BIT];
            status_q[GIE_BIT]  <= 1'b0;
        end else if (ret_en_i) begin
            status_q[GIE_BIT]  <= status_q[PGIE_BIT];
            status_q[PGIE_BIT] <= 1'b1;
        end else if (csr_we_i) begin
            case (addr_i)
                A_STATUS:  status_q  <= new_val & STATUS_WMASK;
                A_IE:      ie_q      <= new_val & IE_WMASK;
                A_TVEC:    tvec_q    <= new_val & ALIGN_MASK;
                A_SCRATCH: scratch_q <= new_val;
                A_EPC:     epc_q     <= new_val & ALIGN_MASK;
                A_CAUSE:   cause_q   <= new_val;
                A_TVAL:    tval_q    <= new_val;
                default:   ;
            endcase
        end
    end

    assign status_ie_o  = status_q[GIE_BIT];
    assign status_pie_o = status_q[PGIE_BIT];
    assign tvec_o       = tvec_q;
    assign epc_o        = epc_q;
endmodule

// File: rtl/utrap_seq.sv
module utrap_seq
    import utrap_pkg::*;
(
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            csr_valid_i,
    input  logic            illegal_i,
    input  logic            write_req_i,
    input  logic            exc_valid_i,
    input  logic [30:0]     exc_code_i,
    input  logic [XLEN-1:0] exc_tval_i,
    input  logic            irq_hit_i,
    input  logic            ret_valid_i,
    output logic            trap_en_o,
    output logic [XLEN-1:0] trap_cause_o,
    output logic [XLEN-1:0] trap_tval_o,
    output logic            ret_en_o,
    output logic            csr_we_o,
    output logic            redirect_o,
    output logic            redirect_ret_o
);
    typedef enum logic [2:0] {
        EV_NONE, EV_EXC, EV_ILLEGAL, EV_IRQ, EV_ACCESS, EV_RET
    } event_e;

    seq_state_e state_q, state_d;
    event_e     ev;

    // winner of this cycle, highest priority first
    always_comb begin
        if (exc_valid_i)                    ev = EV_EXC;
        else if (csr_valid_i && illegal_i)  ev = EV_ILLEGAL;
        else if (irq_hit_i)                 ev = EV_IRQ;
        else if (csr_valid_i)               ev = EV_ACCESS;
        else if (ret_valid_i)               ev = EV_RET;
        else                                ev = EV_NONE;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (ev == EV_EXC || ev == EV_ILLEGAL || ev == EV_IRQ) begin
                    state_d = ST_TRAP_JUMP;
                end else if (ev == EV_RET) begin
                    state_d = ST_RET_JUMP;
                end
            end
            ST_TRAP_JUMP: state_d = ST_RUN;
            ST_RET_JUMP:  state_d = ST_RUN;
            default:      state_d = ST_RUN;
        endcase
    end

    always_comb begin
        trap_en_o      = 1'b0;
        trap_cause_o   = '0;
        trap_tval_o    = '0;
        ret_en_o       = 1'b0;
        csr_we_o       = 1'b0;
        redirect_o     = 1'b0;
        redirect_ret_o = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                unique case (ev)
                    EV_EXC: begin
                        trap_en_o    = 1'b1;
                        trap_cause_o = {1'b0, exc_code_i};
                        trap_tval_o  = exc_tval_i;
                    end
                    EV_ILLEGAL: begin
                        trap_en_o    = 1'b1;
                        trap_cause_o = CAUSE_ILLEGAL;
                    end
                    EV_IRQ: begin
                        trap_en_o    = 1'b1;
                        trap_cause_o = CAUSE_TIMER_IRQ;
                    end
                    EV_ACCESS: csr_we_o = write_req_i;
                    EV_RET:    ret_en_o = 1'b1;
                    EV_NONE:   ;
                    default:   ;
                endcase
            end
            ST_TRAP_JUMP: redirect_o = 1'b1;
            ST_RET_JUMP: begin
                redirect_o     = 1'b1;
                redirect_ret_o = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/utrap_csr_unit.sv
module utrap_csr_unit
    import utrap_pkg::*;
(
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        csr_valid_i,
    input  logic [1:0]  csr_op_i,
    input  logic [11:0] csr_addr_i,
    input  logic [31:0] csr_operand_i,
    input  logic        csr_src_zero_i,
    output logic [31:0] csr_rdata_o,
    input  logic [31:0] pc_i,
    input  logic        exc_valid_i,
    input  logic [30:0] exc_code_i,
    input  logic [31:0] exc_tval_i,
    input  logic        ret_valid_i,
    input  logic        retire_i,
    input  logic        time_tick_i,
    input  logic        irq_timer_i,
    output logic        redirect_valid_o,
    output logic [31:0] redirect_pc_o
);
    logic [NUM_CNT-1:0][CNT_W-1:0] cnt_w;
    logic [XLEN-1:0] trap_cause_w, trap_tval_w, tvec_w, epc_w;
    logic trap_en_w, ret_en_w, csr_we_w, illegal_w, write_req_w, irq_hit_w;
    logic status_ie_w, status_pie_w, redirect_ret_w;

    utrap_counters #(.W(CNT_W), .N(NUM_CNT)) u_cnt (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .inc_i  ({retire_i, time_tick_i, 1'b1}),
        .cnt_o  (cnt_w)
    );

    utrap_regs #(.W(CNT_W), .N(NUM_CNT)) u_regs (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .addr_i       (csr_addr_i),
        .op_i         (csr_op_e'(csr_op_i)),
        .operand_i    (csr_operand_i),
        .src_zero_i   (csr_src_zero_i),
        .csr_we_i     (csr_we_w),
        .trap_en_i    (trap_en_w),
        .trap_cause_i (trap_cause_w),
        .trap_tval_i  (trap_tval_w),
        .pc_i         (pc_i),
        .ret_en_i     (ret_en_w),
        .irq_timer_i  (irq_timer_i),
        .cnt_i        (cnt_w),
        .rdata_o      (csr_rdata_o),
        .illegal_o    (illegal_w),
        .write_req_o  (write_req_w),
        .irq_hit_o    (irq_hit_w),
        .status_ie_o  (status_ie_w),
        .status_pie_o (status_pie_w),
        .tvec_o       (tvec_w),
        .epc_o        (epc_w)
    );

    utrap_seq u_seq (
        .clk_i          (clk_i),
        .rst_ni         (rst_ni),
        .csr_valid_i    (csr_valid_i),
        .illegal_i      (illegal_w),
        .write_req_i    (write_req_w),
        .exc_valid_i    (exc_valid_i),
        .exc_code_i     (exc_code_i),
        .exc_tval_i     (exc_tval_i),
        .irq_hit_i      (irq_hit_w),
        .ret_valid_i    (ret_valid_i),
        .trap_en_o      (trap_en_w),
        .trap_cause_o   (trap_cause_w),
        .trap_tval_o    (trap_tval_w),
        .ret_en_o       (ret_en_w),
        .csr_we_o       (csr_we_w),
        .redirect_o     (redirect_valid_o),
        .redirect_ret_o (redirect_ret_w)
    );

    assign redirect_pc_o = redirect_ret_w ? epc_w : tvec_w;
endmodule

// File: rtl/utrap_csr_sva.sv
module utrap_csr_sva (
    input logic        clk_i,
    input logic        rst_ni,
    input logic        exc_valid_i,
    input logic        redirect_valid_o,
    input logic [31:0] redirect_pc_o,
    input logic [31:0] tvec_w,
    input logic [31:0] epc_w,
    input logic        trap_en_w,
    input logic        ret_en_w,
    input logic        csr_we_w,
    input logic        status_ie_w,
    input logic        status_pie_w,
    input logic [63:0] cycle_w
);
    // R7: an exception in RUN leads to a redirect to the handler base
    a_r7_exc_to_handler: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (exc_valid_i && !redirect_valid_o) |=> (redirect_valid_o && redirect_pc_o == $past(tvec_w)));

    // R10: an accepted return redirects to the saved PC
    a_r10_ret_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ret_en_w |=> (redirect_valid_o && redirect_pc_o == $past(epc_w)));

    // R10: enable restored from the previous-enable bit, which becomes 1
    a_r10_ret_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ret_en_w |=> (status_ie_w == $past(status_pie_w) && status_pie_w));

    // R8: a trap clears the enable and keeps its old value
    a_r8_trap_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trap_en_w |=> (!status_ie_w && status_pie_w == $past(status_ie_w)));

    // R12: a redirect lasts one cycle
    a_r12_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        redirect_valid_o |=> !redirect_valid_o);

    // R12: nothing is committed while a redirect is presented
    a_r12_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        redirect_valid_o |-> !(trap_en_w || ret_en_w || csr_we_w));

    // R5: the cycle counter rises by one on every clock
    a_r5_cycle_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rst_ni |=> (cycle_w == $past(cycle_w) + 64'd1));
endmodule

bind utrap_csr_unit utrap_csr_sva u_sva (
    .clk_i            (clk_i),
    .rst_ni           (rst_ni),
    .exc_valid_i      (exc_valid_i),
    .redirect_valid_o (redirect_valid_o),
    .redirect_pc_o    (redirect_pc_o),
    .tvec_w           (tvec_w),
    .epc_w            (epc_w),
    .trap_en_w        (trap_en_w),
    .ret_en_w         (ret_en_w),
    .csr_we_w         (csr_we_w),
    .status_ie_w      (status_ie_w),
    .status_pie_w     (status_pie_w),
    .cycle_w          (cnt_w[0])
);

// File: tb/tb_utrap_csr_unit.sv
module tb_utrap_csr_unit;
    localparam logic [1:0] RD = 2'b00, WR = 2'b01, ST = 2'b10, CL = 2'b11;

    logic        clk = 1'b0;
    logic        rst_ni = 1'b0;
    logic        csr_valid_i = 1'b0;
    logic [1:0]  csr_op_i = 2'b00;
    logic [11:0] csr_addr_i = '0;
    logic [31:0] csr_operand_i = '0;
    logic        csr_src_zero_i = 1'b0;
    logic [31:0] csr_rdata_o;
    logic [31:0] pc_i = 32'h100;
    logic        exc_valid_i = 1'b0;
    logic [30:0] exc_code_i = '0;
    logic [31:0] exc_tval_i = '0;
    logic        ret_valid_i = 1'b0;
    logic        retire_i = 1'b0;
    logic        time_tick_i = 1'b0;
    logic        irq_timer_i = 1'b0;
    logic        redirect_valid_o;
    logic [31:0] redirect_pc_o;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    utrap_csr_unit dut (.*, .clk_i(clk));

    // behavioural reference state
    logic [31:0] m_status = 0, m_ie = 0, m_tvec = 0, m_scratch = 0;
    logic [31:0] m_epc = 0, m_cause = 0, m_tval = 0;
    longint unsigned m_cnt[3] = '{0, 0, 0};
    int m_mode = 0; // 0 run, 1 trap redirect, 2 return redirect

    function automatic bit m_is_cnt(input logic [11:0] a);
        return (a == 12'hC00 || a == 12'hC01 || a == 12'hC02 ||
                a == 12'hC80 || a == 12'hC81 || a == 12'hC82);
    endfunction

    function automatic bit m_known(input logic [11:0] a);
        return m_is_cnt(a) || a == 12'h000 || a == 12'h004 || a == 12'h005 ||
               (a >= 12'h040 && a <= 12'h044);
    endfunction

    function automatic logic [31:0] m_read(input logic [11:0] a);
        longint unsigned c;
        if (m_is_cnt(a)) begin
            c = m_cnt[a[1:0]];
            return a[7] ? c[63:32] : c[31:0];
        end
        case (a)
            12'h000: return m_status;
            12'h004: return m_ie;
            12'h005: return m_tvec;
            12'h040: return m_scratch;
            12'h041: return m_epc;
            12'h042: return m_cause;
            12'h043: return m_tval;
            12'h044: return irq_timer_i ? 32'h10 : 32'h0;
            default: return 32'h0;
        endcase
    endfunction

    task automatic m_write(input logic [11:0] a, input logic [31:0] v);
        case (a)
            12'h000: m_status = v & 32'h11;
            12'h004: m_ie = v & 32'h111;
            12'h005: m_tvec = v & ~32'h3;
            12'h040: m_scratch = v;
            12'h041: m_epc = v & ~32'h3;
            12'h042: m_cause = v;
            12'h043: m_tval = v;
            default: ;
        endcase
    endtask

    task automatic m_trap(input logic [31:0] cause, input logic [31:0] tval);
        m_epc = pc_i & ~32'h3;
        m_cause = cause;
        m_tval = tval;
        m_status = {m_status[31:5], m_status[0], m_status[3:1], 1'b0};
        m_mode = 1;
    endtask

    task automatic check(input string tag, input string what, input logic [31:0] got,
                         input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
        end
    endtask

    // compare outputs, then advance the model and the clock by one cycle
    task automatic step(input string tag);
        logic [31:0] old, nv;
        bit wants, illegal, irq;
        #5;
        check(tag, "rdata", csr_rdata_o, m_read(csr_addr_i));
        check(tag, "redirect_valid", {31'b0, redirect_valid_o}, {31'b0, m_mode != 0});
        if (m_mode == 1) check(tag, "redirect_pc", redirect_pc_o, m_tvec);
        if (m_mode == 2) check(tag, "redirect_pc", redirect_pc_o, m_epc);
        old = m_read(csr_addr_i);
        wants = (csr_op_i == WR) || ((csr_op_i == ST || csr_op_i == CL) && !csr_src_zero_i);
        illegal = !m_known(csr_addr_i) || (m_is_cnt(csr_addr_i) && wants);
        irq = m_status[0] && m_ie[4] && irq_timer_i;
        if (m_mode != 0) m_mode = 0;
        else if (exc_valid_i) m_trap({1'b0, exc_code_i}, exc_tval_i);
        else if (csr_valid_i && illegal) m_trap(32'd2, 32'd0);
        else if (irq) m_trap(32'h8000_0004, 32'd0);
        else if (csr_valid_i) begin
            if (wants) begin
                nv = (csr_op_i == WR) ? csr_operand_i :
                     (csr_op_i == ST) ? (old | csr_operand_i) : (old & ~csr_operand_i);
                m_write(csr_addr_i, nv);
            end
        end else if (ret_valid_i) begin
            m_status = {m_status[31:5], 1'b1, m_status[3:1], m_status[4]};
            m_mode = 2;
        end
        m_cnt[0]++;
        if (time_tick_i) m_cnt[1]++;
        if (retire_i) m_cnt[2]++;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic cyc(input bit v, input logic [1:0] op, input logic [11:0] a,
                       input logic [31:0] d, input bit sz, input bit ex,
                       input logic [30:0] code, input logic [31:0] tv, input bit rt,
                       input logic [31:0] pc, input string tag);
        csr_valid_i = v; csr_op_i = op; csr_addr_i = a; csr_operand_i = d;
        csr_src_zero_i = sz; exc_valid_i = ex; exc_code_i = code; exc_tval_i = tv;
        ret_valid_i = rt; pc_i = pc;
        step(tag);
        csr_valid_i = 0; csr_op_i = RD; csr_addr_i = 12'h000; csr_operand_i = 0;
        csr_src_zero_i = 0; exc_valid_i = 0; exc_code_i = 0; exc_tval_i = 0; ret_valid_i = 0;
    endtask

    task automatic acc(input logic [1:0] op, input logic [11:0] a, input logic [31:0] d,
                       input bit sz, input string tag);
        cyc(1, op, a, d, sz, 0, 0, 0, 0, 32'h100, tag);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) cyc(0, RD, 12'h000, 0, 0, 0, 0, 0, 0, 32'h100, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_ni = 1'b1;
        // R1: reset values
        idle(2, "R1");
        acc(RD, 12'h000, 0, 1, "R1"); acc(RD, 12'h004, 0, 1, "R1");
        acc(RD, 12'h005, 0, 1, "R1");
        for (int a = 12'h040; a <= 12'h044; a++) acc(RD, a[11:0], 0, 1, "R1");
        // R3: write/set/clear semantics and write masks
        acc(WR, 12'h040, 32'hDEAD_BEEF, 0, "R3");
        acc(ST, 12'h040, 32'h0000_0F00, 0, "R3");
        acc(CL, 12'h040, 32'hF000_000F, 0, "R3");
        acc(RD, 12'h040, 0, 1, "R3");
        acc(WR, 12'h004, 32'hFFFF_FFFF, 0, "R3");
        acc(CL, 12'h004, 32'h0000_0011, 0, "R3");
        acc(RD, 12'h004, 0, 1, "R3");
        acc(WR, 12'h000, 32'hFFFF_FFFF, 0, "R3");
        acc(RD, 12'h000, 0, 1, "R3");
        acc(WR, 12'h000, 32'h0, 0, "R3");
        acc(WR, 12'h005, 32'h0000_2003, 0, "R3");
        acc(WR, 12'h041, 32'h0000_0457, 0, "R3");
        acc(WR, 12'h042, 32'h1234_5678, 0, "R3");
        acc(WR, 12'h043, 32'hCAFE_F00D, 0, "R3");
        acc(WR, 12'h044, 32'hFFFF_FFFF, 0, "R3");
        acc(RD, 12'h005, 0, 1, "R3"); acc(RD, 12'h041, 0, 1, "R3");
        acc(RD, 12'h044, 0, 1, "R3");
        // R4: no write for read op and zero-source set/clear
        acc(ST, 12'h040, 32'hFFFF_FFFF, 1, "R4");
        acc(CL, 12'h040, 32'hFFFF_FFFF, 1, "R4");
        acc(RD, 12'h040, 32'h5555_5555, 0, "R4");
        acc(RD, 12'h040, 0, 1, "R4");
        // R5: counters
        for (int i = 0; i < 6; i++) begin
            time_tick_i = (i % 2 == 0);
            retire_i = (i % 3 == 0);
            idle(1, "R5");
        end
        time_tick_i = 0; retire_i = 0;
        acc(RD, 12'hC00, 0, 1, "R5"); acc(RD, 12'hC80, 0, 1, "R5");
        acc(RD, 12'hC01, 0, 1, "R5"); acc(RD, 12'hC81, 0, 1, "R5");
        acc(RD, 12'hC02, 0, 1, "R5"); acc(ST, 12'hC82, 0, 1, "R5");
        // R2: live pending bit, ignored while interrupts are disabled (R9)
        irq_timer_i = 1;
        acc(RD, 12'h044, 0, 1, "R2");
        idle(2, "R9");
        irq_timer_i = 0;
        acc(RD, 12'h044, 0, 1, "R2");
        acc(RD, 12'h7C0, 0, 1, "R2");
        // R6: illegal accesses
        cyc(1, WR, 12'hC00, 32'h5, 0, 0, 0, 0, 0, 32'h0000_0207, "R6");
        idle(1, "R6");
        acc(RD, 12'h042, 0, 1, "R6"); acc(RD, 12'h041, 0, 1, "R6");
        acc(RD, 12'h043, 0, 1, "R6");
        cyc(1, RD, 12'h7C0, 0, 1, 0, 0, 0, 0, 32'h0000_0210, "R6");
        idle(1, "R6");
        cyc(1, CL, 12'hC02, 32'h1, 0, 0, 0, 0, 0, 32'h0000_0220, "R6");
        idle(1, "R6");
        acc(RD, 12'h042, 0, 1, "R6");
        // R7 and R8: synchronous exception with enable set
        acc(WR, 12'h000, 32'h1, 0, "R8");
        cyc(0, RD, 0, 0, 0, 1, 31'd5, 32'h0000_1234, 0, 32'h0000_0300, "R7");
        idle(1, "R7");
        acc(RD, 12'h042, 0, 1, "R7"); acc(RD, 12'h043, 0, 1, "R7");
        acc(RD, 12'h041, 0, 1, "R7"); acc(RD, 12'h000, 0, 1, "R8");
        // R10: return
        cyc(0, RD, 0, 0, 0, 0, 0, 0, 1, 32'h0000_2000, "R10");
        idle(1, "R10");
        acc(RD, 12'h000, 0, 1, "R10");
        // R9: interrupt preempts a legal write
        acc(WR, 12'h004, 32'h10, 0, "R9");
        irq_timer_i = 1;
        cyc(1, WR, 12'h040, 32'h55, 0, 0, 0, 0, 0, 32'h0000_0400, "R9");
        idle(3, "R9");
        acc(RD, 12'h040, 0, 1, "R9"); acc(RD, 12'h042, 0, 1, "R9");
        acc(RD, 12'h041, 0, 1, "R9");
        irq_timer_i = 0;
        // R11: priorities
        cyc(1, WR, 12'hC00, 32'h1, 0, 1, 31'd7, 32'h77, 0, 32'h0000_0500, "R11");
        idle(1, "R11");
        acc(RD, 12'h042, 0, 1, "R11");
        acc(WR, 12'h000, 32'h1, 0, "R11");
        irq_timer_i = 1;
        cyc(0, RD, 0, 0, 0, 1, 31'd3, 32'h33, 0, 32'h0000_0600, "R11");
        idle(1, "R11");
        irq_timer_i = 0;
        acc(RD, 12'h042, 0, 1, "R11");
        cyc(1, WR, 12'h040, 32'h99, 0, 0, 0, 0, 1, 32'h0000_0700, "R11");
        idle(1, "R11");
        acc(RD, 12'h040, 0, 1, "R11");
        // R12: requests during the redirect cycle are dropped
        cyc(0, RD, 0, 0, 0, 1, 31'd9, 32'h9, 0, 32'h0000_0800, "R12");
        irq_timer_i = 1;
        cyc(1, WR, 12'h040, 32'hAA, 0, 1, 31'd11, 32'hB, 1, 32'h0000_0900, "R12");
        irq_timer_i = 0;
        idle(1, "R12");
        acc(RD, 12'h040, 0, 1, "R12"); acc(RD, 12'h042, 0, 1, "R12");
        acc(RD, 12'h041, 0, 1, "R12");
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule